// File: doc/BRIEF.md
# SPI Control Register Slave with Burst Addressing

This block is a four-wire SPI slave that gives a host access to the bank of configuration registers of a clock generator. The serial lines (select, clock and data in) are brought into a faster system clock domain through synchronisers, and SCLK edges are found there. Each frame starts with a command byte. The command byte is a 7-bit register address, sent MSB first, followed by one direction bit. One or more data bytes follow it, and the register address moves up by one after every data byte. Data bytes are either written into the bank or shifted out on the serial output.

The register bank sends its fields straight to the analog and PLL control logic. These fields are a low-power (hibernate) request, an enable and a 3-bit drive strength for each of two outputs, the 7-bit integer and 17-bit fractional parts of the PLL feedback divider, and two 8-bit output divider values. The serial output is meant for a tri-state pad. This block supplies the data bit and the pad's drive enable. The enable is released at once whenever the select line is high.

Top module: `spireg_slave`

## Requirements
- R1: After reset, hibernate is 0, both output enables are 1, both drive strengths are 3'b111, the integer divider is 66, the fractional divider is 17'h15555, and both output dividers are 24.
- R2: The first byte of a frame is the command byte. MOSI is sampled on rising SCLK edges, MSB first. Command bits 7..1 are the start address and bit 0 is the direction: 1 means read, 0 means write.
- R3: In a write frame, data byte k (counting from 0) is stored at start address + k. Each byte is committed only once its eighth bit has been sampled.
- R4: Register layout, all values byte wide. 0x10 bit 5 is hibernate. 0x11 holds {drive2[2:0], enable2, drive1[2:0], enable1} from bit 7 down to bit 0. 0x13 holds fractional[7:0] and 0x14 holds fractional[15:8]. 0x15 holds {integer[6:0], fractional[16]}. 0x16 is output divider 1 and 0x17 is output divider 2.
- R5: In a read frame, data byte k returns the register at start address + k, MSB first. The serial output changes after falling SCLK edges. MOSI content after the command byte has no effect on any register.
- R6: Writes to addresses outside the layout of R4 change no field. Those addresses read as 0x00. Bits of 0x10 other than bit 5 read as 0.
- R7: During a burst the address wraps from 0x7F to 0x00 and keeps advancing.
- R8: When the select line goes high in the middle of a byte, the partial byte is discarded. The next frame restarts at bit 0 of a new command byte.
- R9: The serial output's drive enable is high exactly while the select line is low.
- R10: A value written to a mapped register reads back unchanged in the bits R4 defines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than SCLK |
| rst | input | 1 | Synchronous active-high reset |
| spi_ss_n | input | 1 | Frame select, active low |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_en | output | 1 | Drive enable for the serial output pad |
| hibernate | output | 1 | Low-power request |
| out1_en | output | 1 | Output 1 enable |
| out1_drv | output | 3 | Output 1 drive strength |
| out2_en | output | 1 | Output 2 enable |
| out2_drv | output | 3 | Output 2 drive strength |
| pll_n | output | 7 | PLL feedback divider, integer part |
| pll_f | output | 17 | PLL feedback divider, fractional part |
| div_m1 | output | 8 | Output 1 divider |
| div_m2 | output | 8 | Output 2 divider |

## Verification
When the eighth bit of a write byte is sampled, two things happen on the same rising SCLK edge: the byte is committed and the address advances. The sharpest version of this is at address 0x7F, where the address must wrap to 0x00 at the same moment a byte is stored. The bench provokes this with a nineteen-byte burst that starts at 0x7F, so its 18th and 19th bytes land on the hibernate and output-control registers. The result is judged by comparing every field against a behavioural register model on each clock. Readback bursts are checked bit by bit against that model at the sampling point just before each rising edge.

// File: rtl/spireg_pkg.sv
package spireg_pkg;

    localparam int ADDR_W  = 7;
    localparam int DATA_W  = 8;
    localparam int DRV_W   = 3;
    localparam int N_W     = 7;
    localparam int F_W     = 17;
    localparam int M_W     = 8;
    localparam int HIB_BIT = 5;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] byte_t;

    localparam addr_t A_PWR  = 7'h10;
    localparam addr_t A_OUT  = 7'h11;
    localparam addr_t A_FLO  = 7'h13;
    localparam addr_t A_FMID = 7'h14;
    localparam addr_t A_NHI  = 7'h15;
    localparam addr_t A_M1   = 7'h16;
    localparam addr_t A_M2   = 7'h17;

    typedef enum logic {PH_CMD, PH_DATA} phase_e;

    typedef struct packed {
        logic             en;
        logic [DRV_W-1:0] drv;
    } drv_cfg_t;

    typedef struct packed {
        logic           hib;
        drv_cfg_t       out1;
        drv_cfg_t       out2;
        logic [N_W-1:0] n;
        logic [F_W-1:0] f;
        logic [M_W-1:0] m1;
        logic [M_W-1:0] m2;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{
        hib:  1'b0,
        out1: '{en: 1'b1, drv: 3'b111},
        out2: '{en: 1'b1, drv: 3'b111},
        n:    7'd66,
        f:    17'h15555,
        m1:   8'd24,
        m2:   8'd24
    };

    function automatic logic is_mapped(addr_t a);
        return (a == A_PWR) || (a == A_OUT) || (a == A_FLO) || (a == A_FMID) ||
               (a == A_NHI) || (a == A_M1)  || (a == A_M2);
    endfunction

    // Byte view of the bank; unmapped addresses and unused bits read as zero.
    function automatic byte_t read_reg(cfg_t c, addr_t a);
        byte_t r;
        r = '0;
        case (a)
            A_PWR:   r[HIB_BIT] = c.hib;
            A_OUT:   r = {c.out2.drv, c.out2.en, c.out1.drv, c.out1.en};
            A_FLO:   r = c.f[7:0];
            A_FMID:  r = c.f[15:8];
            A_NHI:   r = {c.n, c.f[F_W-1]};
            A_M1:    r = c.m1;
            A_M2:    r = c.m2;
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic cfg_t write_reg(cfg_t c, addr_t a, byte_t d);
        cfg_t r;
        r = c;
        case (a)
            A_PWR:   r.hib = d[HIB_BIT];
            A_OUT:   {r.out2.drv, r.out2.en, r.out1.drv, r.out1.en} = d;
            A_FLO:   r.f[7:0]  = d;
            A_FMID:  r.f[15:8] = d;
            A_NHI:   {r.n, r.f[F_W-1]} = d;
            A_M1:    r.m1 = d;
            A_M2:    r.m2 = d;
            default: r = c;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/spireg_sync.sv
module spireg_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{RST_VAL[i]}};
                else     chain <= {chain[STAGES-2:0], d[i]};
            end
            assign q[i] = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/spireg_engine.sv
module spireg_engine
    import spireg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ss_hi,
    input  logic  sclk_s,
    input  logic  mosi_s,
    input  byte_t rdata,
    output addr_t addr,
    output logic  wr_stb,
    output byte_t wdata,
    output logic  miso_q
);

    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    logic              sclk_d;
    logic              rise, fall;
    phase_e            phase;
    logic              rd_mode;
    logic [CNT_W-1:0]  bitcnt;
    logic [DATA_W-2:0] rx;
    byte_t             tx;
    byte_t             rx_byte;
    logic              byte_done;

    always_ff @(posedge clk) begin
        if (rst) sclk_d <= 1'b0;
        else     sclk_d <= sclk_s;
    end

    assign rise      = sclk_s & ~sclk_d;
    assign fall      = ~sclk_s & sclk_d;
    assign rx_byte   = {rx, mosi_s};
    assign byte_done = rise && (bitcnt == LAST_BIT);

    // A high select clears the framing state, so a partial byte is dropped
    // and every falling select edge finds the bit counter at zero.
    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_CMD;
            rd_mode <= 1'b0;
            bitcnt  <= '0;
            rx      <= '0;
            tx      <= '0;
            addr    <= '0;
            wr_stb  <= 1'b0;
            wdata   <= '0;
            miso_q  <= 1'b0;
        end else if (ss_hi) begin
            phase   <= PH_CMD;
            rd_mode <= 1'b0;
            bitcnt  <= '0;
            wr_stb  <= 1'b0;
            miso_q  <= 1'b0;
        end else begin
            wr_stb <= 1'b0;
            if (wr_stb) addr <= addr + 1'b1;
            if (rise) begin
                bitcnt <= bitcnt + 1'b1;
                rx     <= rx_byte[DATA_W-2:0];
            end
            if (byte_done) begin
                if (phase == PH_CMD) begin
                    addr    <= addr_t'(rx_byte >> 1);
                    rd_mode <= rx_byte[0];
                    phase   <= PH_DATA;
                end else if (rd_mode) begin
                    addr <= addr + 1'b1;
                end else begin
                    wr_stb <= 1'b1;
                    wdata  <= rx_byte;
                end
            end
            if (fall && (phase == PH_DATA) && rd_mode) begin
                if (bitcnt == '0) begin
                    miso_q <= rdata[DATA_W-1];
                    tx     <= {rdata[DATA_W-2:0], 1'b0};
                end else begin
                    miso_q <= tx[DATA_W-1];
                    tx     <= {tx[DATA_W-2:0], 1'b0};
                end
            end
        end
    end

    p_addr_step_r3: assert property (@(posedge clk) disable iff (rst || ss_hi)
        wr_stb |=> addr == $past(addr) + 1'b1);

    p_addr_wrap_r7: assert property (@(posedge clk) disable iff (rst || ss_hi)
        (wr_stb && addr == '1) |=> addr == '0);

    p_frame_clear_r8: assert property (@(posedge clk) disable iff (rst)
        ss_hi |=> (bitcnt == '0 && phase == PH_CMD && !wr_stb));

    p_miso_idle_r5: assert property (@(posedge clk) disable iff (rst)
        !rd_mode |-> !miso_q);

endmodule

// File: rtl/spireg_regbank.sv
module spireg_regbank
    import spireg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  addr_t waddr,
    input  byte_t wdata,
    input  addr_t raddr,
    output byte_t rdata,
    output cfg_t  cfg
);

    always_ff @(posedge clk) begin
        if (rst)        cfg <= CFG_RESET;
        else if (wr_en) cfg <= write_reg(cfg, waddr, wdata);
    end

    assign rdata = read_reg(cfg, raddr);

    p_hib_write_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && waddr == A_PWR) |=> cfg.hib == $past(wdata[HIB_BIT]));

    p_unmapped_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !is_mapped(waddr)) |=> $stable(cfg));

endmodule

// File: rtl/spireg_slave.sv
module spireg_slave
    import spireg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             spi_ss_n,
    input  logic             spi_sclk,
    input  logic             spi_mosi,
    output logic             spi_miso,
    output logic             spi_miso_en,
    output logic             hibernate,
    output logic             out1_en,
    output logic [DRV_W-1:0] out1_drv,
    output logic             out2_en,
    output logic [DRV_W-1:0] out2_drv,
    output logic [N_W-1:0]   pll_n,
    output logic [F_W-1:0]   pll_f,
    output logic [M_W-1:0]   div_m1,
    output logic [M_W-1:0]   div_m2
);

    localparam int SIG_W = 3;

    logic [SIG_W-1:0] pins_s;
    addr_t            addr;
    logic             wr_stb;
    byte_t            wdata;
    byte_t            rdata;
    cfg_t             cfg;

    spireg_sync #(
        .W       (SIG_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({spi_ss_n, spi_sclk, spi_mosi}),
        .q   (pins_s)
    );

    spireg_engine u_engine (
        .clk    (clk),
        .rst    (rst),
        .ss_hi  (pins_s[2]),
        .sclk_s (pins_s[1]),
        .mosi_s (pins_s[0]),
        .rdata  (rdata),
        .addr   (addr),
        .wr_stb (wr_stb),
        .wdata  (wdata),
        .miso_q (spi_miso)
    );

    spireg_regbank u_bank (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_stb),
        .waddr (addr),
        .wdata (wdata),
        .raddr (addr),
        .rdata (rdata),
        .cfg   (cfg)
    );

    // The pad is released straight from the pin, with no synchroniser delay.
    assign spi_miso_en = ~spi_ss_n;

    assign hibernate = cfg.hib;
    assign out1_en   = cfg.out1.en;
    assign out1_drv  = cfg.out1.drv;
    assign out2_en   = cfg.out2.en;
    assign out2_drv  = cfg.out2.drv;
    assign pll_n     = cfg.n;
    assign pll_f     = cfg.f;
    assign div_m1    = cfg.m1;
    assign div_m2    = cfg.m2;

endmodule

// File: tb/sim_spireg_slave.sv
module sim_spireg_slave;

    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ss_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
    logic miso, miso_en, hib, en1, en2;
    logic [2:0] drv1, drv2;
    logic [6:0] n;
    logic [16:0] f;
    logic [7:0] m1, m2;

    int errors = 0, checks = 0, cyc = 0, last_upd = -100;
    bit done = 0;

    // behavioural model of the register fields
    logic m_hib = 0, m_en1 = 1, m_en2 = 1;
    logic [2:0] m_drv1 = 3'b111, m_drv2 = 3'b111;
    logic [6:0] m_n = 7'd66;
    logic [16:0] m_f = 17'h15555;
    logic [7:0] m_m1 = 8'd24, m_m2 = 8'd24;

    always #4 clk = ~clk;

    spireg_slave u0 (
        .clk(clk), .rst(rst), .spi_ss_n(ss_n), .spi_sclk(sclk), .spi_mosi(mosi),
        .spi_miso(miso), .spi_miso_en(miso_en), .hibernate(hib),
        .out1_en(en1), .out1_drv(drv1), .out2_en(en2), .out2_drv(drv2),
        .pll_n(n), .pll_f(f), .div_m1(m1), .div_m2(m2)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at cycle %0d: got %h expected %h", req, cyc, got, exp);
        end
    endtask

    function automatic logic [63:0] dut_vec();
        return {15'd0, hib, en1, drv1, en2, drv2, n, f, m1, m2};
    endfunction

    function automatic logic [63:0] model_vec();
        return {15'd0, m_hib, m_en1, m_drv1, m_en2, m_drv2, m_n, m_f, m_m1, m_m2};
    endfunction

    function automatic logic [7:0] mread(input int a);
        case (a)
            'h10: return {2'b00, m_hib, 5'b0};
            'h11: return {m_drv2, m_en2, m_drv1, m_en1};
            'h13: return m_f[7:0];
            'h14: return m_f[15:8];
            'h15: return {m_n, m_f[16]};
            'h16: return m_m1;
            'h17: return m_m2;
            default: return 8'h00;
        endcase
    endfunction

    task automatic mwrite(input int a, input logic [7:0] d);
        case (a)
            'h10: m_hib = d[5];
            'h11: begin m_drv2 = d[7:5]; m_en2 = d[4]; m_drv1 = d[3:1]; m_en1 = d[0]; end
            'h13: m_f[7:0] = d;
            'h14: m_f[15:8] = d;
            'h15: begin m_n = d[7:1]; m_f[16] = d[0]; end
            'h16: m_m1 = d;
            'h17: m_m2 = d;
            default: ;
        endcase
    endtask

    // per-clock comparison of the fields and the pad enable (R4, R9)
    always @(negedge clk) begin
        cyc++;
        if (!rst && !done) begin
            check(miso_en == !ss_n, "R9", {63'd0, miso_en}, {63'd0, !ss_n});
            if (cyc - last_upd > 8)
                check(dut_vec() == model_vec(), "R4", dut_vec(), model_vec());
        end
    end

    // One frame: full bytes in b, then tail_bits of a partial byte of ones.
    task automatic frame(input logic [7:0] b[$], input int tail_bits);
        bit rd;
        int a;
        @(negedge clk); ss_n = 1'b0;
        repeat (4) @(negedge clk);
        rd = (b.size() > 0) ? b[0][0] : 1'b0;
        a  = (b.size() > 0) ? int'(b[0][7:1]) : 0;
        for (int i = 0; i < b.size(); i++) begin
            logic [7:0] got, exp;
            int ra;
            ra  = (a + i - 1) & 127;
            exp = (i > 0 && rd) ? mread(ra) : 8'h00;
            got = 8'h00;
            for (int k = 7; k >= 0; k--) begin
                @(negedge clk); mosi = b[i][k];
                repeat (HALF) @(negedge clk);
                got[k] = miso;
                if (k == 0 && i > 0 && !rd) begin
                    mwrite(ra, b[i]);
                    last_upd = cyc;
                end
                sclk = 1'b1;
                repeat (HALF) @(negedge clk);
                sclk = 1'b0;
            end
            if (i > 0 && rd)
                check(got == exp, "R5", {56'd0, got}, {56'd0, exp});
        end
        for (int k = 0; k < tail_bits; k++) begin
            @(negedge clk); mosi = 1'b1;
            repeat (HALF) @(negedge clk); sclk = 1'b1;
            repeat (HALF) @(negedge clk); sclk = 1'b0;
        end
        repeat (3) @(negedge clk); ss_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    initial begin
        logic [7:0] q[$];
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state against constants
        check({hib, en1, drv1, en2, drv2} == 9'b0_1111_1111, "R1", {55'd0, hib, en1, drv1, en2, drv2}, 64'h0ff);
        check(n == 7'd66 && f == 17'h15555, "R1", {40'd0, n, f}, {40'd0, 7'd66, 17'h15555});
        check(m1 == 8'd24 && m2 == 8'd24, "R1", {48'd0, m1, m2}, {48'd0, 8'd24, 8'd24});
        check(miso_en == 1'b0, "R9", {63'd0, miso_en}, 64'd0);

        // R2/R4: single write to output control 0x11 = 0x5A
        q = '{8'h22, 8'h5A}; frame(q, 0);
        check({drv2, en2, drv1, en1} == 8'h5A, "R4", {56'd0, drv2, en2, drv1, en1}, 64'h5A);

        // R3: burst across divider registers
        q = '{8'h26, 8'h8E, 8'hE3, 8'h8A, 8'h05, 8'h19}; frame(q, 0);
        check(f == 17'h0E38E && n == 7'd69, "R3", {40'd0, n, f}, {40'd0, 7'd69, 17'h0E38E});
        check(m1 == 8'd5 && m2 == 8'd25, "R3", {48'd0, m1, m2}, {48'd0, 8'd5, 8'd25});

        // R4/R6: hibernate write of all ones, readback shows only bit 5
        q = '{8'h20, 8'hFF}; frame(q, 0);
        check(hib == 1'b1, "R4", {63'd0, hib}, 64'd1);
        q = '{8'h21, 8'h00}; frame(q, 0);

        // R5/R10: read burst 0x10..0x17 with MOSI garbage after the command
        q = '{8'h21, 8'hFF, 8'hA5, 8'h00, 8'hFF, 8'h3C, 8'hFF, 8'h81, 8'hFF}; frame(q, 0);
        check(hib == 1'b1 && m2 == 8'd25, "R5", {55'd0, hib, m2}, {55'd0, 1'b1, 8'd25});

        // R6: unmapped writes, then unmapped readback
        q = '{8'h24, 8'hFF, 8'h00}; frame(q, 0);
        q = '{8'h40, 8'hFF, 8'hFF}; frame(q, 0);
        q = '{8'h25, 8'h00, 8'h00}; frame(q, 0);
        check(dut_vec() == model_vec(), "R6", dut_vec(), model_vec());

        // R7: burst from 0x7F wraps; bytes 18 and 19 hit 0x10 and 0x11
        q = '{8'hFE};
        for (int i = 1; i <= 19; i++) q.push_back(8'hFF);
        q[18] = 8'h00; q[19] = 8'h33;
        frame(q, 0);
        check(hib == 1'b0, "R7", {63'd0, hib}, 64'd0);
        check({drv2, en2, drv1, en1} == 8'h33, "R7", {56'd0, drv2, en2, drv1, en1}, 64'h33);

        // R8: partial data byte dropped
        q = '{8'h22}; frame(q, 5);
        check({drv2, en2, drv1, en1} == 8'h33, "R8", {56'd0, drv2, en2, drv1, en1}, 64'h33);
        // R8: partial command, then a clean frame restarts at bit 0
        q = '{}; frame(q, 4);
        q = '{8'h20, 8'h20}; frame(q, 0);
        check(hib == 1'b1, "R8", {63'd0, hib}, 64'd1);

        // R2: read-direction frame with data on MOSI writes nothing
        q = '{8'h2D, 8'h00, 8'h00}; frame(q, 0);
        check(m1 == 8'd5 && m2 == 8'd25, "R2", {48'd0, m1, m2}, {48'd0, 8'd5, 8'd25});

        // R10: write then read back the output control register
        q = '{8'h22, 8'hC6}; frame(q, 0);
        q = '{8'h23, 8'h00}; frame(q, 0);
        check({drv2, en2, drv1, en1} == 8'hC6, "R10", {56'd0, drv2, en2, drv1, en1}, 64'hC6);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule